// File: doc/BRIEF.md
# Cascadable Active-Low Priority Encoder

This block finds the highest-numbered active request among a wide set of request lines. It is built from identical 8-input slices with active-low request inputs and active-low code outputs. Each slice also has an enable input, a group flag that is low when the slice has found a request, and an enable output. A slice drives its enable output low only when it is enabled and sees no request. That output enables the next slice down the chain, so a wider encoder needs no separate comparator tree.

The top level chains four slices into a 32-input encoder. The slice covering lines 31..24 sits at the head of the chain, and line 7 ranks highest inside each slice. The top level builds the 5-bit active-high result from the slices' outputs. The two upper bits come from the position of the one slice whose group flag is low. The three lower bits are the OR of the inverted slice codes, which works because at most one slice can hold a request. A parameter selects an output register for timing closure, which adds one cycle of latency. The lowest slice's enable output is brought out so a further stage can be chained below this one.

Top module: `prioEncoderCascade`

## Requirements
- R1: A slice whose active-low enable input is high drives all code outputs high, its group flag high and its enable output high, whatever its requests are.
- R2: An enabled slice with all eight request inputs high drives all code outputs high and its group flag high, and drives its enable output low.
- R3: An enabled slice with at least one request low drives the bitwise complement of the highest-numbered low request's index on its code outputs (input 7 ranks highest), drives its group flag low and its enable output high.
- R4: With the top enable low and any reqN bit low, the top drives valid=1 and code equal to the highest-numbered low bit of reqN. Requests in lower slices have no effect on the result.
- R5: With the top enable low and all reqN bits high, the top drives valid=0, code=0 and chainEnOutN=0.
- R6: With the top enable high, the top drives valid=0, code=0 and chainEnOutN=1 for any reqN.
- R7: With REG_OUT=1 (the default), the outputs show the inputs present at the previous rising clock edge. While rstN is low, the outputs are held at valid=0, code=0, chainEnOutN=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rstN | input | 1 | Asynchronous active-low reset of the output register |
| enN | input | 1 | Active-low enable of the head slice |
| reqN | input | 32 | Active-low request lines; bit 31 has top priority |
| code | output | 5 | Active-high index of the highest active request |
| valid | output | 1 | High when any request was found |
| chainEnOutN | output | 1 | Active-low enable for a further stage below; low when enabled and idle |

## Verification
One slice is driven through all 256 request patterns, with the enable both high and low. This separates a wrong priority order, a wrong code polarity and wrong handling of the flags at the idle and disabled boundaries. The 32-input top is then driven with every one-hot pattern, which shows that each line maps to its own code. It is also driven with every pattern that has bit 31 set plus random lower bits, which shows that lower slices are suppressed. Random patterns, the all-idle and disabled cases, a latency probe and a reset probe cover the chain wiring and the output register.

// File: rtl/prioEncoderPkg.sv
package prioEncoderPkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;    // capture new result into output register
    logic bypass;  // route combinational result to the ports
  } prioStrobes_t;

endpackage

// File: rtl/prioSlice.sv
module prioSlice #(
  parameter int WIDTH = 8,
  localparam int CW = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] reqN,
  input  logic             enInN,
  output logic [CW-1:0]    codeN,
  output logic             gotN,
  output logic             enOutN
);

  logic [CW-1:0] hiIdx;
  logic          anyReq;

  // Scan upward so the last hit (highest index) wins
  always_comb begin
    hiIdx  = '0;
    anyReq = 1'b0;
    for (int i = 0; i < WIDTH; i++) begin
      if (!reqN[i]) begin
        hiIdx  = CW'(i);
        anyReq = 1'b1;
      end
    end
  end

  always_comb begin
    if (enInN) begin
      codeN  = '1;
      gotN   = 1'b1;
      enOutN = 1'b1;
    end else if (anyReq) begin
      codeN  = ~hiIdx;
      gotN   = 1'b0;
      enOutN = 1'b1;
    end else begin
      codeN  = '1;
      gotN   = 1'b1;
      enOutN = 1'b0;
    end
  end

endmodule

// File: rtl/prioCtrl.sv
module prioCtrl
  import prioEncoderPkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic         rstN,
  output prioStrobes_t strobes
);

  always_comb begin
    strobes.load   = rstN;
    strobes.bypass = !REG_OUT;
  end

endmodule

// File: rtl/prioDatapath.sv
module prioDatapath
  import prioEncoderPkg::*;
#(
  parameter int NUM_SLICES = 4,
  parameter int SLICE_W    = 8,
  localparam int TOTAL  = NUM_SLICES * SLICE_W,
  localparam int CW     = $clog2(SLICE_W),
  localparam int GW     = $clog2(NUM_SLICES),
  localparam int CODE_W = GW + CW
) (
  input  logic              clk,
  input  logic              rstN,
  input  prioStrobes_t      strobes,
  input  logic              enN,
  input  logic [TOTAL-1:0]  reqN,
  output logic [CODE_W-1:0] code,
  output logic              valid,
  output logic              chainEnOutN
);

  logic [NUM_SLICES:0]   enChainN;
  logic [NUM_SLICES-1:0] gotN;
  logic [CW-1:0]         sliceCodeN [NUM_SLICES];

  assign enChainN[NUM_SLICES] = enN;

  // Head of chain is the top slice; each enable-out feeds the slice below
  for (genvar s = 0; s < NUM_SLICES; s++) begin : gSlice
    prioSlice #(.WIDTH(SLICE_W)) uSlice (
      .reqN   (reqN[s*SLICE_W +: SLICE_W]),
      .enInN  (enChainN[s+1]),
      .codeN  (sliceCodeN[s]),
      .gotN   (gotN[s]),
      .enOutN (enChainN[s])
    );
  end

  logic [GW-1:0]     grpBits;
  logic [CW-1:0]     lowBits;
  logic [CODE_W-1:0] combCode;
  logic              combValid;

  always_comb begin
    grpBits = '0;
    lowBits = '0;
    for (int s = 0; s < NUM_SLICES; s++) begin
      if (!gotN[s]) grpBits = grpBits | GW'(s);
      lowBits = lowBits | ~sliceCodeN[s];
    end
    combValid = ~&gotN;
    combCode  = {grpBits, lowBits};
  end

  logic [CODE_W-1:0] codeQ;
  logic              validQ;
  logic              chainQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      codeQ  <= '0;
      validQ <= 1'b0;
      chainQ <= 1'b1;
    end else if (strobes.load) begin
      codeQ  <= combCode;
      validQ <= combValid;
      chainQ <= enChainN[0];
    end
  end

  assign code        = strobes.bypass ? combCode    : codeQ;
  assign valid       = strobes.bypass ? combValid   : validQ;
  assign chainEnOutN = strobes.bypass ? enChainN[0] : chainQ;

endmodule

// File: rtl/prioEncoderCascade.sv
module prioEncoderCascade
  import prioEncoderPkg::*;
#(
  parameter int NUM_SLICES = 4,
  parameter int SLICE_W    = 8,
  parameter bit REG_OUT    = 1'b1,
  localparam int TOTAL  = NUM_SLICES * SLICE_W,
  localparam int CODE_W = $clog2(NUM_SLICES) + $clog2(SLICE_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enN,
  input  logic [TOTAL-1:0]  reqN,
  output logic [CODE_W-1:0] code,
  output logic              valid,
  output logic              chainEnOutN
);

  prioStrobes_t strobes;

  prioCtrl #(.REG_OUT(REG_OUT)) uCtrl (
    .rstN    (rstN),
    .strobes (strobes)
  );

  prioDatapath #(.NUM_SLICES(NUM_SLICES), .SLICE_W(SLICE_W)) uPath (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .enN         (enN),
    .reqN        (reqN),
    .code        (code),
    .valid       (valid),
    .chainEnOutN (chainEnOutN)
  );

endmodule

// File: rtl/prioEncoderChecker.sv
module prioEncoderChecker #(
  parameter int TOTAL  = 32,
  parameter int CODE_W = 5,
  parameter bit REG_OUT = 1'b1
) (
  input logic              clk,
  input logic              rstN,
  input logic              enN,
  input logic [TOTAL-1:0]  reqN,
  input logic [CODE_W-1:0] code,
  input logic              valid,
  input logic              chainEnOutN
);

  logic [TOTAL-1:0] prevReq;
  logic             prevEn;
  logic             prevRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevReq <= '1;
      prevEn  <= 1'b1;
      prevRun <= 1'b0;
    end else begin
      prevReq <= reqN;
      prevEn  <= enN;
      prevRun <= 1'b1;
    end
  end

  if (REG_OUT) begin : gRegChecks
    // R4
    highest_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
      (prevRun && valid) |-> (((~prevReq) >> code) == TOTAL'(1)));

    // R5
    idle_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
      (prevRun && !prevEn && (&prevReq)) |-> (!valid && code == '0 && !chainEnOutN));

    // R6
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
      (prevRun && prevEn) |-> (!valid && code == '0 && chainEnOutN));

    // R4
    found_blocks_chain_chk: assert property (@(posedge clk) disable iff (!rstN)
      valid |-> chainEnOutN);

    // R7
    invalid_zero_code_chk: assert property (@(posedge clk) disable iff (!rstN)
      !valid |-> (code == '0));
  end

endmodule

bind prioEncoderCascade prioEncoderChecker #(
  .TOTAL(TOTAL), .CODE_W(CODE_W), .REG_OUT(REG_OUT)
) chk (
  .clk(clk), .rstN(rstN), .enN(enN), .reqN(reqN),
  .code(code), .valid(valid), .chainEnOutN(chainEnOutN)
);

// File: tb/tb_prioEncoderCascade.sv
module tb_prioEncoderCascade;

  localparam int CLK_PERIOD = 10;
  localparam int TOTAL = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enN = 1'b1;
  logic [TOTAL-1:0] reqN = '1;
  logic [4:0] code;
  logic valid;
  logic chainEnOutN;

  logic [7:0] sReqN = '1;
  logic sEnN = 1'b1;
  logic [2:0] sCodeN;
  logic sGotN, sEnOutN;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prioEncoderCascade dut (
    .clk(clk), .rstN(rstN), .enN(enN), .reqN(reqN),
    .code(code), .valid(valid), .chainEnOutN(chainEnOutN)
  );

  prioSlice #(.WIDTH(8)) sliceDut (
    .reqN(sReqN), .enInN(sEnN), .codeN(sCodeN), .gotN(sGotN), .enOutN(sEnOutN)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected top outputs {code, valid, chainEnOutN}
  function automatic logic [6:0] refTop(input logic en_n, input logic [31:0] r);
    logic [6:0] res;
    if (en_n) return {5'd0, 1'b0, 1'b1};
    res = {5'd0, 1'b0, 1'b0};
    for (int i = 0; i < 32; i++)
      if (!r[i]) res = {5'(i), 1'b1, 1'b1};
    return res;
  endfunction

  function automatic logic [4:0] refSlice(input logic en_n, input logic [7:0] r);
    logic [4:0] res;
    if (en_n) return 5'b11111;
    res = {3'b111, 1'b1, 1'b0};
    for (int i = 0; i < 8; i++)
      if (!r[i]) res = {~3'(i), 1'b0, 1'b1};
    return res;
  endfunction

  // Drive at negedge, sample a quarter period after the capturing edge
  task automatic applyTop(input logic en_n, input logic [31:0] r, input string req);
    @(negedge clk);
    enN = en_n;
    reqN = r;
    @(posedge clk);
    #(CLK_PERIOD/4);
    check(req, {25'd0, code, valid, chainEnOutN}, {25'd0, refTop(en_n, r)});
  endtask

  task automatic testReset();
    @(negedge clk);
    enN = 1'b0;
    reqN = 32'hFFFF_FFFE;
    rstN = 1'b0;
    #1;
    check("R7 reset", {25'd0, code, valid, chainEnOutN}, {25'd0, 5'd0, 1'b0, 1'b1});
    @(posedge clk);
    #(CLK_PERIOD/4);
    check("R7 reset held", {25'd0, code, valid, chainEnOutN}, {25'd0, 5'd0, 1'b0, 1'b1});
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic testSliceExhaustive();
    for (int e = 0; e < 2; e++) begin
      for (int p = 0; p < 256; p++) begin
        sEnN = e[0];
        sReqN = 8'(p);
        #1;
        if (e == 1) check("R1 slice disabled", {27'd0, sCodeN, sGotN, sEnOutN}, {27'd0, refSlice(1'b1, 8'(p))});
        else if (p == 255) check("R2 slice idle", {27'd0, sCodeN, sGotN, sEnOutN}, {27'd0, refSlice(1'b0, 8'(p))});
        else check("R3 slice priority", {27'd0, sCodeN, sGotN, sEnOutN}, {27'd0, refSlice(1'b0, 8'(p))});
      end
    end
  endtask

  task automatic testOneHot();
    for (int i = 0; i < TOTAL; i++) applyTop(1'b0, ~(32'd1 << i), "R4 one-hot");
  endtask

  task automatic testTopBitSet();
    for (int k = 0; k < 200; k++) applyTop(1'b0, {1'b0, 31'($urandom)}, "R4 top bit masks lower");
  endtask

  task automatic testRandom();
    for (int k = 0; k < 300; k++) applyTop(1'b0, $urandom | $urandom | $urandom, "R4 random");
  endtask

  task automatic testIdle();
    applyTop(1'b0, 32'hFFFF_FFFF, "R5 idle");
  endtask

  task automatic testDisabled();
    applyTop(1'b1, 32'h0000_0000, "R6 disabled all req");
    applyTop(1'b1, 32'h7FFF_FFFF, "R6 disabled top req");
    applyTop(1'b1, 32'hFFFF_FFFF, "R6 disabled idle");
  endtask

  task automatic testLatency();
    applyTop(1'b0, ~(32'd1 << 9), "R7 latency setup");
    @(negedge clk);
    reqN = ~(32'd1 << 20);
    #1;
    check("R7 output holds before edge", {25'd0, code, valid, chainEnOutN}, {25'd0, 5'd9, 1'b1, 1'b1});
    @(posedge clk);
    #(CLK_PERIOD/4);
    check("R7 output updates after edge", {25'd0, code, valid, chainEnOutN}, {25'd0, 5'd20, 1'b1, 1'b1});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    testReset();
    testSliceExhaustive();
    testOneHot();
    testTopBitSet();
    testRandom();
    testIdle();
    testDisabled();
    testLatency();
    testReset();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule